// File: doc/BRIEF.md
# Clock Request/Acknowledge Responder

This block serves one requester over a four-phase request/acknowledge handshake. When the requester asks for a clock, the block passes a free-running reference clock through an enable to make a gated output clock. It then confirms with an acknowledge once that clock is running. When the requester withdraws, the block first drops the acknowledge and then stops the clock.

The order is deliberately asymmetric. On the way up, the clock starts before the acknowledge rises. On the way down, the acknowledge falls before the clock stops. Every step waits its own bounded pseudo-random number of reference cycles.

Each wait is drawn fresh from a free-running linear feedback shift register. The draw is the minimum delay plus the low four register bits, which gives 10 to 25 reference cycles. The request passes through a two-flop synchronizer before the sequencer sees it. The enable is held in a latch that is transparent while the reference clock is low, so the output clock is made only of whole reference pulses and rests low when stopped.

Top module: `clkhs_responder`

## Requirements
- R1: While `rst_n` is low, `ack` is low and `clk_out` is low, whatever `req` does, and an assertion of `rst_n` in mid-handshake forces both low at once.
- R2: After `req` rises, counting reference rising edges from the first one that sees it high, the first edge carrying an output pulse is number 14 to 29: two synchronizer cycles, one decision cycle, then a 10 to 25 cycle wait, then one cycle to open the latch.
- R3: Counting output clock pulses from the first one, `ack` rises on the edge of pulse number 10 to 25.
- R4: After `req` falls in the steady acknowledged state, `ack` falls on reference edge number 13 to 28, counted from the first edge that sees `req` low.
- R5: After `ack` falls, exactly 10 to 25 further output pulses appear as one unbroken run, and then `clk_out` stays low.
- R6: Whenever `ack` is high the output clock is enabled, so neither acknowledge edge occurs while the clock is stopped.
- R7: Every wait draws a fresh value of 10 plus the low four bits of a never-zero 16-bit shift register, so the delays vary from one handshake to the next and always lie in 10 to 25.
- R8: A change of the synchronized request during a wait is ignored until that wait ends. A request dropped while the block waits to raise `ack` still sees `ack` rise, and `ack` then falls on reference edge 11 to 26 after the edge that raised it.
- R9: `clk_out` is never high while the reference clock is low, so no runt or extended pulse appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset; the block is active only while high |
| req | input | 1 | Clock request from the requester, asynchronous |
| clk_out | output | 1 | Gated copy of the reference clock |
| ack | output | 1 | Acknowledge to the requester |

## Verification
Normal handshakes are run with short, medium and long hold times between `ack` rising and `req` falling. These show whether each of the four waits is measured from the right event and whether the clock run before and after the acknowledge edges has the right length. Handshakes where `req` is dropped right after the clock starts tell a sequencer that honours a request change mid-wait apart from one that finishes the phase first. A reset during an active handshake shows whether both outputs are forced low at once. Comparing the drawn delays across handshakes tells a fresh draw per wait apart from a fixed delay.

// File: rtl/clkhs_pkg.sv
`timescale 1ns/1ps
package clkhs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_CLK_ON,
    ST_WAIT_ACK_HI,
    ST_ACTIVE,
    ST_WAIT_ACK_LO,
    ST_WAIT_CLK_OFF
  } hs_state_t;

  // Map a random word into [dmin, dmin + 2**span_w - 1].
  function automatic int unsigned draw_delay(input int unsigned rnd,
                                             input int unsigned dmin,
                                             input int unsigned span_w);
    return dmin + (rnd & ((32'd1 << span_w) - 32'd1));
  endfunction

endpackage

// File: rtl/clkhs_sync.sv
`timescale 1ns/1ps
module clkhs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_in};
  end

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/clkhs_lfsr.sv
`timescale 1ns/1ps
module clkhs_lfsr #(
  parameter int               WIDTH = 16,
  parameter logic [WIDTH-1:0] TAPS  = 16'hB400,
  parameter logic [WIDTH-1:0] SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [WIDTH-1:0] state_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= (state_q >> 1) ^ (state_q[0] ? TAPS : '0);
  end
endmodule

// File: rtl/clkhs_gate.sv
`timescale 1ns/1ps
module clkhs_gate (
  input  logic clk_in,
  input  logic rst_n,
  input  logic en,
  output logic clk_gated,
  output logic en_held
);
  always_latch begin
    if (!rst_n)       en_held = 1'b0;
    else if (!clk_in) en_held = en;
  end

  assign clk_gated = clk_in & en_held;
endmodule

// File: rtl/clkhs_responder.sv
`timescale 1ns/1ps
module clkhs_responder
  import clkhs_pkg::*;
#(
  parameter int               DLY_MIN     = 10,
  parameter int               SPAN_W      = 4,
  parameter int               LFSR_W      = 16,
  parameter logic [LFSR_W-1:0] LFSR_SEED  = 16'hACE1,
  parameter int               SYNC_STAGES = 2
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic req,
  output logic clk_out,
  output logic ack
);
  localparam int DLY_MAX = DLY_MIN + (1 << SPAN_W) - 1;
  localparam int CNT_W   = $clog2(DLY_MAX + 1);

  logic              req_s;
  logic [LFSR_W-1:0] lfsr_q;
  logic [CNT_W-1:0]  dly_draw;
  logic [CNT_W-1:0]  cnt_q;
  logic              dly_load;
  logic              wait_done;
  logic              in_wait;
  logic              clk_en_q;
  logic              ack_q;
  logic              en_held;
  hs_state_t         state_q, state_nxt;

  clkhs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_ref), .rst_n(rst_n), .d_in(req), .d_out(req_s)
  );

  clkhs_lfsr #(.WIDTH(LFSR_W), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk_ref), .rst_n(rst_n), .state_q(lfsr_q)
  );

  assign dly_draw  = CNT_W'(draw_delay(32'(lfsr_q), DLY_MIN, SPAN_W));
  assign wait_done = (cnt_q == CNT_W'(1));
  assign in_wait   = (state_q == ST_WAIT_CLK_ON) || (state_q == ST_WAIT_ACK_HI) ||
                     (state_q == ST_WAIT_ACK_LO) || (state_q == ST_WAIT_CLK_OFF);

  always_comb begin
    state_nxt = state_q;
    dly_load  = 1'b0;
    unique case (state_q)
      ST_IDLE:         if (req_s)     begin state_nxt = ST_WAIT_CLK_ON;  dly_load = 1'b1; end
      ST_WAIT_CLK_ON:  if (wait_done) begin state_nxt = ST_WAIT_ACK_HI;  dly_load = 1'b1; end
      ST_WAIT_ACK_HI:  if (wait_done)       state_nxt = ST_ACTIVE;
      ST_ACTIVE:       if (!req_s)    begin state_nxt = ST_WAIT_ACK_LO;  dly_load = 1'b1; end
      ST_WAIT_ACK_LO:  if (wait_done) begin state_nxt = ST_WAIT_CLK_OFF; dly_load = 1'b1; end
      ST_WAIT_CLK_OFF: if (wait_done)       state_nxt = ST_IDLE;
      default:                              state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      clk_en_q <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      state_q <= state_nxt;
      if (dly_load)           cnt_q <= dly_draw;
      else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
      clk_en_q <= (state_nxt == ST_WAIT_ACK_HI) || (state_nxt == ST_ACTIVE) ||
                  (state_nxt == ST_WAIT_ACK_LO) || (state_nxt == ST_WAIT_CLK_OFF);
      ack_q    <= (state_nxt == ST_ACTIVE) || (state_nxt == ST_WAIT_ACK_LO);
    end
  end

  clkhs_gate u_gate (
    .clk_in(clk_ref), .rst_n(rst_n), .en(clk_en_q),
    .clk_gated(clk_out), .en_held(en_held)
  );

  assign ack = ack_q;
endmodule

// File: rtl/clkhs_checks.sv
`timescale 1ns/1ps
module clkhs_checks #(
  parameter int DLY_MIN = 10,
  parameter int SPAN_W  = 4,
  parameter int LFSR_W  = 16,
  parameter int CNT_W   = 5
) (
  input logic              clk_ref,
  input logic              rst_n,
  input logic              ack_q,
  input logic              clk_en_q,
  input logic              dly_load,
  input logic [CNT_W-1:0]  dly_draw,
  input logic [LFSR_W-1:0] lfsr_q,
  input logic              in_wait,
  input logic              wait_done,
  input logic [2:0]        state_q
);
  localparam int DLY_MAX = DLY_MIN + (1 << SPAN_W) - 1;

  AST_RESET_QUIET: assert property (@(posedge clk_ref)
    !rst_n |-> (!ack_q && !clk_en_q)); // R1

  AST_ACK_NEEDS_CLK: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ack_q |-> clk_en_q); // R6

  AST_ACK_RISE_AFTER_CLK: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(ack_q) |-> $past(clk_en_q)); // R3

  AST_CLK_STOP_AFTER_ACK: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(clk_en_q) |-> (!ack_q && !$past(ack_q))); // R5

  AST_DELAY_RANGE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    dly_load |-> ((int'(dly_draw) >= DLY_MIN) && (int'(dly_draw) <= DLY_MAX))); // R7

  AST_LFSR_NONZERO: assert property (@(posedge clk_ref) disable iff (!rst_n)
    lfsr_q != '0); // R7

  AST_WAIT_HOLDS: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (in_wait && !wait_done) |=> $stable(state_q)); // R8
endmodule

bind clkhs_responder clkhs_checks #(
  .DLY_MIN(DLY_MIN), .SPAN_W(SPAN_W), .LFSR_W(LFSR_W), .CNT_W(CNT_W)
) u_checks (
  .clk_ref(clk_ref), .rst_n(rst_n), .ack_q(ack_q), .clk_en_q(clk_en_q),
  .dly_load(dly_load), .dly_draw(dly_draw), .lfsr_q(lfsr_q),
  .in_wait(in_wait), .wait_done(wait_done), .state_q(state_q)
);

// File: tb/clkhs_responder_bench.sv
`timescale 1ns/1ps
module clkhs_responder_bench;
  logic clk_ref = 1'b0;
  logic rst_n   = 1'b0;
  logic req     = 1'b0;
  logic clk_out;
  logic ack;

  int tests = 0;
  int fails = 0;
  int runt_cnt = 0;
  int ack_dly [6];
  int off_dly [6];

  // {drop request right after clock start, hold cycles after ack}
  localparam logic [8:0] VEC [6] = '{
    {1'b0, 8'd3}, {1'b0, 8'd40}, {1'b1, 8'd0},
    {1'b0, 8'd1}, {1'b1, 8'd0},  {1'b0, 8'd12}
  };

  always #2.5 clk_ref = ~clk_ref;

  clkhs_responder u_clkhs_responder (
    .clk_ref(clk_ref), .rst_n(rst_n), .req(req), .clk_out(clk_out), .ack(ack)
  );

  always @(negedge clk_ref) begin
    #1;
    if (clk_out) runt_cnt++;
  end

  task automatic tick();
    @(posedge clk_ref);
    #1;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int lo, input int hi);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic handshake(input int idx, input bit early, input int hold);
    int n;
    int p;
    int q;
    int last;
    @(negedge clk_ref);
    req = 1'b1;
    n = 0;
    do begin tick(); n++; end while (!clk_out && n < 60);
    check(n >= 14 && n <= 29, "R2 req rise to first pulse", n, 14, 29);
    if (early) begin
      @(negedge clk_ref);
      req = 1'b0;
    end
    p = 1;
    do begin tick(); if (clk_out) p++; end while (!ack && p < 60);
    check(ack && p >= 10 && p <= 25, "R3 pulses up to ack rise", p, 10, 25);
    check(clk_out === 1'b1, "R6 clock running at ack rise", int'(clk_out), 1, 1);
    ack_dly[idx] = p;
    if (!early) begin
      repeat (hold) tick();
      @(negedge clk_ref);
      req = 1'b0;
      n = 0;
      do begin tick(); n++; end while (ack && n < 60);
      check(n >= 13 && n <= 28, "R4 req fall to ack fall", n, 13, 28);
    end else begin
      n = 0;
      do begin tick(); n++; end while (ack && n < 60);
      check(n >= 11 && n <= 26, "R8 early drop, ack fall gap", n, 11, 26);
    end
    q = 0;
    last = 0;
    for (int i = 1; i <= 40; i++) begin
      tick();
      if (clk_out) begin q++; last = i; end
    end
    check(q == last && q >= 10 && q <= 25, "R5 pulses after ack fall", q, 10, 25);
    off_dly[idx] = q;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int bad;
    bit varied;
    // R1: reset holds outputs low even with request high
    bad = 0;
    repeat (3) tick();
    @(negedge clk_ref);
    req = 1'b1;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (ack || clk_out) bad++;
    end
    check(bad == 0, "R1 outputs quiet in reset", bad, 0, 0);
    @(negedge clk_ref);
    req = 1'b0;
    repeat (5) tick();
    @(negedge clk_ref);
    rst_n = 1'b1;
    repeat (5) tick();
    check(!ack && !clk_out, "R1 idle after reset", int'(ack), 0, 0);

    for (int v = 0; v < 6; v++) begin
      handshake(v, VEC[v][8], int'(VEC[v][7:0]));
      repeat (3) tick();
    end

    // R7: fresh draw per wait
    varied = 1'b0;
    for (int v = 1; v < 6; v++)
      if (ack_dly[v] != ack_dly[0] || off_dly[v] != off_dly[0]) varied = 1'b1;
    check(varied, "R7 delays vary across waits", int'(varied), 1, 1);

    // R1: reset in mid-handshake
    @(negedge clk_ref);
    req = 1'b1;
    bad = 0;
    do begin tick(); bad++; end while (!ack && bad < 80);
    check(ack === 1'b1, "R1 setup ack before mid reset", int'(ack), 1, 1);
    @(posedge clk_ref);
    #1;
    rst_n = 1'b0;
    #0.5;
    check(!ack && !clk_out, "R1 mid-handshake reset forces low",
          int'(ack) + int'(clk_out), 0, 0);
    bad = 0;
    for (int i = 0; i < 5; i++) begin
      tick();
      if (ack || clk_out) bad++;
    end
    check(bad == 0, "R1 held low during reset", bad, 0, 0);
    @(negedge clk_ref);
    req = 1'b0;
    rst_n = 1'b1;
    repeat (4) tick();
    handshake(0, 1'b0, 5);

    check(runt_cnt == 0, "R9 no output high while reference low", runt_cnt, 0, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule